// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a byte-wide host write path and a flash array controller. It watches write strobes, each carrying a 19-bit address and a data byte, and recognises the multi-write command sequences that a parallel flash expects. Long commands open with a two-write unlock prefix at two fixed addresses, then a command byte. Suspend, resume, reset and power down also exist as lone single writes. For every recognised operation the block raises one registered, one-cycle command pulse. Program pulses carry the target address and data byte. Sector erase pulses carry an 8-bit mask of the sectors to erase.

Sector erase lets the host queue further sectors after the first one. Each extra `30h` write restarts a window counted in clock cycles (`WIN_CYC`). When the window passes with no further write, the queued mask is issued. While a program or erase runs, the decoder reports the busy read mode and ignores writes, except for a suspend during a sector erase. The `op_done` input ends the busy state. The block also keeps the current read mode. In identifier mode it returns the identification bytes on a small read port.

The FSM states are as follows:
- IDLE: array read.
- KEY1 and KEY2: the first and second unlock writes have been seen.
- PGM_ARM: waiting for the program write.
- ERS_KEY0 and ERS_KEY1: the second unlock, inside the erase sequence.
- ERS_FINAL: the erase selector write.
- ERS_WIN: the sector queueing window.
- IDENT: identifier mode.
- BUSY: a program or a chip erase is running.
- BUSY_ERS: a sector erase is running.
- SUSP: an erase is suspended.

The transitions are unlock-advance, break-to-IDLE, arm-program, issue-program, erase-advance, chip-issue, sector-queue, window-expire, window-abort, enter-ident, lone-reset, power-down, suspend, resume and done-to-IDLE.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The unlock prefix is data AAh at address 05555h, then data 55h at address 02AAAh, then a command byte at 05555h. All 19 address bits are compared. A write that does not match the expected step returns to array read mode and raises no pulse.
- R2: After the prefix, command A0h arms programming. The next write raises `cmd_program` for one cycle, with `cmd_addr`/`cmd_data` equal to that write's address and data, and enters busy.
- R3: After the prefix, the sequence 80h, AAh@05555h, 55h@02AAAh, 10h@05555h raises `cmd_chip_erase` and enters busy. A suspend is not honoured during this busy state.
- R4: The sequence 80h, AAh@05555h, 55h@02AAAh, then 30h at any address opens sector queueing. Each queued address sets mask bit number A18..A16. Each further 30h write adds its sector and restarts the window. A 30h write sampled at the very edge where the window would expire still joins the mask.
- R5: `cmd_sect_erase` pulses, with `cmd_sect_mask` holding the queued mask, `WIN_CYC` edges after the edge that sampled the last queued 30h write, and the block enters busy. Any other write inside the window abandons the erase with no pulse.
- R6: Command 90h enters identifier mode. `id_data` then decodes rd_addr bits (A6,A1,A0): (0,0,0) gives `MFR_CODE`, (0,0,1) gives `DEV_CODE`, and (0,1,0) gives 01h if `sect_prot` bit A18..A16 is set, else 00h. Any other combination, and any read outside identifier mode, gives 00h.
- R7: During a sector erase, B0h at any address raises `cmd_suspend` and enters suspended mode. In suspended mode, 30h at any address raises `cmd_resume` and returns to erase busy. Suspended mode ignores all other writes and `op_done`.
- R8: F0h at any address raises `cmd_reset` and returns to array mode. This applies in idle or identifier mode, and also as the command byte after the unlock prefix.
- R9: In idle or identifier mode, 20h at 05555h raises `cmd_pwrdn` and leaves the block in array mode.
- R10: In busy, writes raise no pulse. `op_done` returns to array mode. When `op_done` and a B0h write arrive in the same cycle during a sector erase, `op_done` wins and no suspend is issued.
- R11: `read_mode` encodes 0 = array, 1 = identifier, 2 = busy, 3 = suspended. After reset it is 0, every pulse is low and every command field is 0.
- R12: Every pulse appears in the cycle after the edge that sampled its write, lasts one cycle, and at most one pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data byte |
| op_done | input | 1 | Running program/erase has finished |
| rd_addr | input | 19 | Read address for identifier decode |
| sect_prot | input | 8 | Per-sector protection status |
| id_data | output | 8 | Identifier read data |
| read_mode | output | 2 | Current read mode |
| cmd_program | output | 1 | Program pulse |
| cmd_chip_erase | output | 1 | Whole-array erase pulse |
| cmd_sect_erase | output | 1 | Sector erase pulse |
| cmd_suspend | output | 1 | Erase suspend pulse |
| cmd_resume | output | 1 | Erase resume pulse |
| cmd_reset | output | 1 | Reset pulse |
| cmd_pwrdn | output | 1 | Deep power-down pulse |
| cmd_addr | output | 19 | Program address |
| cmd_data | output | 8 | Program data |
| cmd_sect_mask | output | 8 | Sectors to erase |

## Verification
Two events can coincide in the sector window: a write that appends a sector, and the window expiring. The bench provokes this by queueing a sector exactly `WIN_CYC` edges after the previous one. It judges the outcome by the erase pulse arriving only after a fresh full window, with a mask that includes the late sector. A second collision is `op_done` arriving with a B0h write during a sector erase. It is judged by the absence of a suspend pulse and a return to array mode. A behavioural reference model compares every output on every clock. This includes a long stretch of random writes and done strobes that lands such collisions in arbitrary states.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_PGM_ARM,
        ST_ERS_KEY0,
        ST_ERS_KEY1,
        ST_ERS_FINAL,
        ST_ERS_WIN,
        ST_IDENT,
        ST_BUSY,
        ST_BUSY_ERS,
        ST_SUSP
    } fsm_t;

    typedef enum logic [1:0] {
        RM_ARRAY = 2'd0,
        RM_IDENT = 2'd1,
        RM_BUSY  = 2'd2,
        RM_SUSP  = 2'd3
    } rmode_t;

    localparam logic [7:0] CB_KEY1   = 8'hAA;
    localparam logic [7:0] CB_KEY2   = 8'h55;
    localparam logic [7:0] CB_PGM    = 8'hA0;
    localparam logic [7:0] CB_ERASE  = 8'h80;
    localparam logic [7:0] CB_CHIP   = 8'h10;
    localparam logic [7:0] CB_SECT   = 8'h30;
    localparam logic [7:0] CB_IDENT  = 8'h90;
    localparam logic [7:0] CB_SUSP   = 8'hB0;
    localparam logic [7:0] CB_RESET  = 8'hF0;
    localparam logic [7:0] CB_PWRDN  = 8'h20;

endpackage

// File: rtl/fcd_win_timer.sv
module fcd_win_timer #(
    parameter int WIN_CYC = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic expired
);
    localparam int CW = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (run && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);

    AST_WIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= LAST)); // R5

    AST_WIN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0)); // R4

endmodule

// File: rtl/fcd_id_read.sv
module fcd_id_read #(
    parameter int         ADDR_W   = 19,
    parameter int         N_SECT   = 8,
    parameter logic [7:0] MFR_CODE = 8'hC2,
    parameter logic [7:0] DEV_CODE = 8'h4B
) (
    input  logic              ident,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [N_SECT-1:0] sect_prot,
    output logic [7:0]        id_data
);
    localparam int SEL_W = $clog2(N_SECT);

    logic [2:0] sel;
    logic       unused_rd;

    assign sel       = {rd_addr[6], rd_addr[1], rd_addr[0]};
    assign unused_rd = ^{rd_addr[ADDR_W-SEL_W-1:7], rd_addr[5:2]};

    always_comb begin
        id_data = 8'h00;
        if (ident) begin
            unique case (sel)
                3'b000:  id_data = MFR_CODE;
                3'b001:  id_data = DEV_CODE;
                3'b010:  id_data = {7'd0, sect_prot[rd_addr[ADDR_W-1 -: SEL_W]]};
                default: id_data = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int         ADDR_W   = 19,
    parameter int         N_SECT   = 8,
    parameter int         WIN_CYC  = 4000,
    parameter logic [7:0] MFR_CODE = 8'hC2,
    parameter logic [7:0] DEV_CODE = 8'h4B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              op_done,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [N_SECT-1:0] sect_prot,
    output logic [7:0]        id_data,
    output logic [1:0]        read_mode,
    output logic              cmd_program,
    output logic              cmd_chip_erase,
    output logic              cmd_sect_erase,
    output logic              cmd_suspend,
    output logic              cmd_resume,
    output logic              cmd_reset,
    output logic              cmd_pwrdn,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_data,
    output logic [N_SECT-1:0] cmd_sect_mask
);
    localparam int SEL_W = $clog2(N_SECT);
    localparam logic [ADDR_W-1:0] UNL_A = ADDR_W'(19'h05555);
    localparam logic [ADDR_W-1:0] UNL_B = ADDR_W'(19'h02AAA);

    fsm_t              st, nxt;
    rmode_t            rm;
    logic [N_SECT-1:0] acc, acc_n, sect_oh;
    logic              hit_a, hit_b, restart, expired;
    logic              p_pgm, p_chip, p_sect, p_susp, p_res, p_rst, p_pd;

    assign hit_a = (wr_addr == UNL_A);
    assign hit_b = (wr_addr == UNL_B);

    always_comb begin
        sect_oh = '0;
        sect_oh[wr_addr[ADDR_W-1 -: SEL_W]] = 1'b1;
    end

    fcd_win_timer #(.WIN_CYC(WIN_CYC)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run     (st == ST_ERS_WIN),
        .expired (expired)
    );

    fcd_id_read #(
        .ADDR_W   (ADDR_W),
        .N_SECT   (N_SECT),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_id (
        .ident     (st == ST_IDENT),
        .rd_addr   (rd_addr),
        .sect_prot (sect_prot),
        .id_data   (id_data)
    );

    always_comb begin
        nxt     = st;
        acc_n   = acc;
        restart = 1'b0;
        p_pgm   = 1'b0;
        p_chip  = 1'b0;
        p_sect  = 1'b0;
        p_susp  = 1'b0;
        p_res   = 1'b0;
        p_rst   = 1'b0;
        p_pd    = 1'b0;
        unique case (st)
            ST_IDLE, ST_IDENT: if (wr_stb) begin
                nxt = ST_IDLE;
                if (wr_data == CB_KEY1 && hit_a)       nxt   = ST_KEY1;
                else if (wr_data == CB_RESET)          p_rst = 1'b1;
                else if (wr_data == CB_PWRDN && hit_a) p_pd  = 1'b1;
            end
            ST_KEY1: if (wr_stb) begin
                nxt = (wr_data == CB_KEY2 && hit_b) ? ST_KEY2 : ST_IDLE;
            end
            ST_KEY2: if (wr_stb) begin
                nxt = ST_IDLE;
                if (wr_data == CB_RESET) p_rst = 1'b1;
                else if (hit_a) begin
                    if (wr_data == CB_PGM)        nxt = ST_PGM_ARM;
                    else if (wr_data == CB_ERASE) nxt = ST_ERS_KEY0;
                    else if (wr_data == CB_IDENT) nxt = ST_IDENT;
                end
            end
            ST_PGM_ARM: if (wr_stb) begin
                p_pgm = 1'b1;
                nxt   = ST_BUSY;
            end
            ST_ERS_KEY0: if (wr_stb) begin
                nxt = (wr_data == CB_KEY1 && hit_a) ? ST_ERS_KEY1 : ST_IDLE;
            end
            ST_ERS_KEY1: if (wr_stb) begin
                nxt = (wr_data == CB_KEY2 && hit_b) ? ST_ERS_FINAL : ST_IDLE;
            end
            ST_ERS_FINAL: if (wr_stb) begin
                nxt = ST_IDLE;
                if (wr_data == CB_CHIP && hit_a) begin
                    p_chip = 1'b1;
                    nxt    = ST_BUSY;
                end else if (wr_data == CB_SECT) begin
                    acc_n   = sect_oh;
                    restart = 1'b1;
                    nxt     = ST_ERS_WIN;
                end
            end
            ST_ERS_WIN: begin
                if (wr_stb) begin
                    if (wr_data == CB_SECT) begin
                        acc_n   = acc | sect_oh;
                        restart = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end else if (expired) begin
                    p_sect = 1'b1;
                    nxt    = ST_BUSY_ERS;
                end
            end
            ST_BUSY: if (op_done) nxt = ST_IDLE;
            ST_BUSY_ERS: begin
                if (op_done) begin
                    nxt = ST_IDLE;
                end else if (wr_stb && wr_data == CB_SUSP) begin
                    p_susp = 1'b1;
                    nxt    = ST_SUSP;
                end
            end
            ST_SUSP: if (wr_stb && wr_data == CB_SECT) begin
                p_res = 1'b1;
                nxt   = ST_BUSY_ERS;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            acc <= '0;
        end else begin
            st  <= nxt;
            acc <= acc_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_program    <= 1'b0;
            cmd_chip_erase <= 1'b0;
            cmd_sect_erase <= 1'b0;
            cmd_suspend    <= 1'b0;
            cmd_resume     <= 1'b0;
            cmd_reset      <= 1'b0;
            cmd_pwrdn      <= 1'b0;
            cmd_addr       <= '0;
            cmd_data       <= '0;
            cmd_sect_mask  <= '0;
        end else begin
            cmd_program    <= p_pgm;
            cmd_chip_erase <= p_chip;
            cmd_sect_erase <= p_sect;
            cmd_suspend    <= p_susp;
            cmd_resume     <= p_res;
            cmd_reset      <= p_rst;
            cmd_pwrdn      <= p_pd;
            if (p_pgm) begin
                cmd_addr <= wr_addr;
                cmd_data <= wr_data;
            end
            if (p_sect) cmd_sect_mask <= acc;
        end
    end

    always_comb begin
        unique case (st)
            ST_IDENT:             rm = RM_IDENT;
            ST_BUSY, ST_BUSY_ERS: rm = RM_BUSY;
            ST_SUSP:              rm = RM_SUSP;
            default:              rm = RM_ARRAY;
        endcase
    end
    assign read_mode = rm;

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_program, cmd_chip_erase, cmd_sect_erase, cmd_suspend,
                  cmd_resume, cmd_reset, cmd_pwrdn})); // R12

    AST_PGM_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_program |=> !cmd_program); // R12

    AST_PGM_FROM_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_program |-> ($past(st) == ST_PGM_ARM)); // R2

    AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_sect_erase |-> (cmd_sect_mask != '0)); // R4

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rm == RM_BUSY && !op_done && !(wr_stb && wr_data == CB_SUSP))
        |=> (rm == RM_BUSY)); // R10

    AST_RESUME_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_resume |-> ($past(rm) == RM_SUSP)); // R7

    AST_BUSY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_program || cmd_chip_erase || cmd_sect_erase) |-> (rm == RM_BUSY)); // R5

endmodule

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;

    localparam int         WIN = 6;
    localparam logic [7:0] MFR = 8'hC2;
    localparam logic [7:0] DEV = 8'h4B;

    localparam int M_IDLE = 0, M_K1 = 1, M_K2 = 2, M_ARM = 3, M_E0 = 4, M_E1 = 5;
    localparam int M_EF = 6, M_WIN = 7, M_BUSY = 8, M_BE = 9, M_SUSP = 10, M_ID = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_stb = 1'b0;
    logic [18:0] b_addr = '0;
    logic [7:0]  b_data = '0;
    logic        b_done = 1'b0;
    logic [18:0] b_rd = '0;
    logic [7:0]  b_prot = 8'b0100_1000;

    logic [7:0]  id_data;
    logic [1:0]  read_mode;
    logic        cmd_program, cmd_chip_erase, cmd_sect_erase, cmd_suspend;
    logic        cmd_resume, cmd_reset, cmd_pwrdn;
    logic [18:0] cmd_addr;
    logic [7:0]  cmd_data;
    logic [7:0]  cmd_sect_mask;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    flash_cmd_decoder #(
        .ADDR_W(19), .N_SECT(8), .WIN_CYC(WIN), .MFR_CODE(MFR), .DEV_CODE(DEV)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_stb(b_stb), .wr_addr(b_addr), .wr_data(b_data),
        .op_done(b_done), .rd_addr(b_rd), .sect_prot(b_prot), .id_data(id_data),
        .read_mode(read_mode), .cmd_program(cmd_program), .cmd_chip_erase(cmd_chip_erase),
        .cmd_sect_erase(cmd_sect_erase), .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume),
        .cmd_reset(cmd_reset), .cmd_pwrdn(cmd_pwrdn), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .cmd_sect_mask(cmd_sect_mask)
    );

    // behavioural reference model
    int          ms = M_IDLE;
    int          mcnt = 0;
    logic [7:0]  macc = '0;
    logic        e_pgm = 0, e_chip = 0, e_sect = 0, e_susp = 0, e_res = 0, e_rst = 0, e_pd = 0;
    logic [18:0] e_addr = '0;
    logic [7:0]  e_data = '0;
    logic [7:0]  e_mask = '0;
    logic        a5, a2;
    logic [7:0]  sb;

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = M_IDLE; mcnt = 0; macc = '0;
            e_pgm = 0; e_chip = 0; e_sect = 0; e_susp = 0; e_res = 0; e_rst = 0; e_pd = 0;
            e_addr = '0; e_data = '0; e_mask = '0;
        end else begin
            e_pgm = 0; e_chip = 0; e_sect = 0; e_susp = 0; e_res = 0; e_rst = 0; e_pd = 0;
            a5 = (b_addr == 19'h05555);
            a2 = (b_addr == 19'h02AAA);
            sb = 8'd1 << b_addr[18:16];
            case (ms)
                M_IDLE, M_ID: if (b_stb) begin
                    if (b_data == 8'hAA && a5) ms = M_K1;
                    else begin
                        ms = M_IDLE;
                        if (b_data == 8'hF0) e_rst = 1;
                        else if (b_data == 8'h20 && a5) e_pd = 1;
                    end
                end
                M_K1: if (b_stb) ms = (b_data == 8'h55 && a2) ? M_K2 : M_IDLE;
                M_K2: if (b_stb) begin
                    ms = M_IDLE;
                    if (b_data == 8'hF0) e_rst = 1;
                    else if (a5 && b_data == 8'hA0) ms = M_ARM;
                    else if (a5 && b_data == 8'h80) ms = M_E0;
                    else if (a5 && b_data == 8'h90) ms = M_ID;
                end
                M_ARM: if (b_stb) begin
                    e_pgm = 1; e_addr = b_addr; e_data = b_data; ms = M_BUSY;
                end
                M_E0: if (b_stb) ms = (b_data == 8'hAA && a5) ? M_E1 : M_IDLE;
                M_E1: if (b_stb) ms = (b_data == 8'h55 && a2) ? M_EF : M_IDLE;
                M_EF: if (b_stb) begin
                    if (b_data == 8'h10 && a5) begin e_chip = 1; ms = M_BUSY; end
                    else if (b_data == 8'h30) begin macc = sb; mcnt = 0; ms = M_WIN; end
                    else ms = M_IDLE;
                end
                M_WIN: begin
                    if (b_stb) begin
                        if (b_data == 8'h30) begin macc = macc | sb; mcnt = 0; end
                        else ms = M_IDLE;
                    end else if (mcnt == WIN - 1) begin
                        e_sect = 1; e_mask = macc; ms = M_BE;
                    end else mcnt++;
                end
                M_BUSY: if (b_done) ms = M_IDLE;
                M_BE: begin
                    if (b_done) ms = M_IDLE;
                    else if (b_stb && b_data == 8'hB0) begin e_susp = 1; ms = M_SUSP; end
                end
                M_SUSP: if (b_stb && b_data == 8'h30) begin e_res = 1; ms = M_BE; end
                default: ms = M_IDLE;
            endcase
        end
    end

    function automatic logic [1:0] exp_mode();
        case (ms)
            M_ID: return 2'd1;
            M_BUSY, M_BE: return 2'd2;
            M_SUSP: return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [7:0] exp_id();
        if (ms != M_ID) return 8'h00;
        case ({b_rd[6], b_rd[1], b_rd[0]})
            3'b000: return MFR;
            3'b001: return DEV;
            3'b010: return {7'd0, b_prot[b_rd[18:16]]};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R11 read_mode", 32'(read_mode), 32'(exp_mode()));
        chk("R2 cmd_program", 32'(cmd_program), 32'(e_pgm));
        chk("R2 cmd_addr", 32'(cmd_addr), 32'(e_addr));
        chk("R2 cmd_data", 32'(cmd_data), 32'(e_data));
        chk("R3 cmd_chip_erase", 32'(cmd_chip_erase), 32'(e_chip));
        chk("R5 cmd_sect_erase", 32'(cmd_sect_erase), 32'(e_sect));
        chk("R4 cmd_sect_mask", 32'(cmd_sect_mask), 32'(e_mask));
        chk("R7 cmd_suspend", 32'(cmd_suspend), 32'(e_susp));
        chk("R7 cmd_resume", 32'(cmd_resume), 32'(e_res));
        chk("R8 cmd_reset", 32'(cmd_reset), 32'(e_rst));
        chk("R9 cmd_pwrdn", 32'(cmd_pwrdn), 32'(e_pd));
        chk("R6 id_data", 32'(id_data), 32'(exp_id()));
        chk("R12 pulse count", 32'($countones({cmd_program, cmd_chip_erase, cmd_sect_erase,
            cmd_suspend, cmd_resume, cmd_reset, cmd_pwrdn}) <= 1), 32'd1);
    endtask

    task automatic step(input logic s, input logic [18:0] a, input logic [7:0] d, input logic dn);
        b_stb = s; b_addr = a; b_data = d; b_done = dn;
        @(posedge clk);
        @(negedge clk);
        compare_all();
        b_stb = 1'b0; b_done = 1'b0;
    endtask

    task automatic wr(input logic [18:0] a, input logic [7:0] d);
        step(1'b1, a, d, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, '0, 1'b0);
    endtask

    task automatic unlock();
        wr(19'h05555, 8'hAA);
        wr(19'h02AAA, 8'h55);
    endtask

    task automatic erase_prefix();
        unlock();
        wr(19'h05555, 8'h80);
        wr(19'h05555, 8'hAA);
        wr(19'h02AAA, 8'h55);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        chk("R11 reset mode", 32'(read_mode), 32'd0);
        chk("R11 reset pulses", 32'({cmd_program, cmd_chip_erase, cmd_sect_erase, cmd_suspend,
            cmd_resume, cmd_reset, cmd_pwrdn}), 32'd0);
        chk("R11 reset mask", 32'(cmd_sect_mask), 32'd0);

        // R2 program
        unlock();
        wr(19'h05555, 8'hA0);
        wr(19'h12345, 8'h3C);
        chk("R2 program pulse", 32'(cmd_program), 32'd1);
        chk("R2 program addr", 32'(cmd_addr), 32'h12345);
        chk("R2 program data", 32'(cmd_data), 32'h3C);
        chk("R2 busy", 32'(read_mode), 32'd2);
        idle(1);
        chk("R12 program one cycle", 32'(cmd_program), 32'd0);
        wr(19'h05555, 8'hB0);
        chk("R10 busy ignores suspend", 32'({cmd_suspend, read_mode}), 32'd2);
        wr(19'h00000, 8'hF0);
        chk("R10 busy ignores reset", 32'({cmd_reset, read_mode}), 32'd2);
        step(1'b0, '0, '0, 1'b1);
        chk("R10 done to array", 32'(read_mode), 32'd0);

        // R3 chip erase, not suspendable
        erase_prefix();
        wr(19'h05555, 8'h10);
        chk("R3 chip pulse", 32'(cmd_chip_erase), 32'd1);
        wr(19'h00000, 8'hB0);
        chk("R3 no suspend in chip erase", 32'({cmd_suspend, read_mode}), 32'd2);
        step(1'b0, '0, '0, 1'b1);

        // R4/R5 sector queueing with append on the expiry edge
        erase_prefix();
        wr(19'h10123, 8'h30);
        wr(19'h50040, 8'h30);
        idle(WIN - 1);
        wr(19'h30000, 8'h30);
        idle(WIN - 1);
        chk("R5 no pulse before window", 32'(cmd_sect_erase), 32'd0);
        idle(1);
        chk("R5 sector pulse", 32'(cmd_sect_erase), 32'd1);
        chk("R4 sector mask", 32'(cmd_sect_mask), 32'h2A);

        // R7 suspend/resume, then R10 done beats suspend
        wr(19'h44444, 8'hB0);
        chk("R7 suspend", 32'({cmd_suspend, read_mode}), 32'h7);
        step(1'b0, '0, '0, 1'b1);
        wr(19'h00000, 8'hF0);
        chk("R7 suspended ignores", 32'({cmd_reset, read_mode}), 32'd3);
        wr(19'h7FFFF, 8'h30);
        chk("R7 resume", 32'({cmd_resume, read_mode}), 32'h6);
        step(1'b1, 19'h00001, 8'hB0, 1'b1);
        chk("R10 done wins", 32'({cmd_suspend, read_mode}), 32'd0);

        // R5 abandoned window
        erase_prefix();
        wr(19'h20000, 8'h30);
        wr(19'h05555, 8'h55);
        chk("R5 abort to array", 32'(read_mode), 32'd0);
        idle(WIN + 2);
        chk("R5 no erase after abort", 32'(cmd_sect_erase), 32'd0);

        // R1 broken prefix
        wr(19'h05555, 8'hAA);
        wr(19'h05555, 8'h55);
        wr(19'h05555, 8'hA0);
        wr(19'h00010, 8'h11);
        chk("R1 break no program", 32'({cmd_program, read_mode}), 32'd0);
        wr(19'h45555, 8'hAA);
        wr(19'h02AAA, 8'h55);
        chk("R1 full address compare", 32'(read_mode), 32'd0);

        // R6 identifier mode
        unlock();
        wr(19'h05555, 8'h90);
        chk("R6 ident mode", 32'(read_mode), 32'd1);
        b_rd = 19'h00000; idle(1);
        chk("R6 manufacturer", 32'(id_data), 32'(MFR));
        b_rd = 19'h00001; idle(1);
        chk("R6 device", 32'(id_data), 32'(DEV));
        b_rd = 19'h30002; idle(1);
        chk("R6 protected sector", 32'(id_data), 32'h01);
        b_rd = 19'h20002; idle(1);
        chk("R6 unprotected sector", 32'(id_data), 32'h00);
        b_rd = 19'h00040; idle(1);
        chk("R6 other selector", 32'(id_data), 32'h00);
        b_rd = 19'h00000;
        wr(19'h1ABCD, 8'hF0);
        chk("R8 lone reset", 32'({cmd_reset, read_mode}), 32'h4);
        chk("R6 outside ident", 32'(id_data), 32'h00);

        // R8 long reset, R9 power down
        unlock();
        wr(19'h33333, 8'hF0);
        chk("R8 long reset", 32'(cmd_reset), 32'd1);
        wr(19'h05555, 8'h20);
        chk("R9 power down", 32'({cmd_pwrdn, read_mode}), 32'h4);
        wr(19'h05554, 8'h20);
        chk("R9 wrong address", 32'(cmd_pwrdn), 32'd0);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [18:0] a;
            logic [7:0]  d;
            case ($urandom % 4)
                0: a = 19'h05555;
                1: a = 19'h02AAA;
                2: a = {3'($urandom), 16'h0000};
                default: a = 19'($urandom);
            endcase
            case ($urandom % 11)
                0: d = 8'hAA; 1: d = 8'h55; 2: d = 8'hA0; 3: d = 8'h80;
                4: d = 8'h10; 5: d = 8'h30; 6: d = 8'h90; 7: d = 8'hB0;
                8: d = 8'hF0; 9: d = 8'h20;
                default: d = 8'($urandom);
            endcase
            b_rd = {3'($urandom), 9'd0, 3'($urandom), 4'd0};
            step(($urandom % 5) < 3, a, d, ($urandom % 16) == 0);
        end
        step(1'b0, '0, '0, 1'b1);

        summary();
        $finish;
    end

endmodule